// File: doc/BRIEF.md
# Text Cursor and Attribute Overlay

This block sits between a text-mode character fetch path and the pixel shifter of a display controller. For every character cell and scan line it decides three per-cell controls. The first says whether the shifted glyph row is inverted. The second says whether every pixel of the row is forced on, which draws an underline. The third says whether the glyph is blanked so that only the background shows. The pixel shifter combines them as `pixel = ((glyph & ~blank) | force_on) ^ invert`.

The cursor is one cell chosen by address. It covers a configurable band of scan lines and is shown in one of four modes: steady, hidden, blinking at 1/16 of the frame rate, or blinking at 1/32 of the frame rate. Per-cell attribute bits add reverse video, blinking and underline. A global reverse-screen bit inverts the whole picture. Both blink rates come from a single frame counter that advances on a frame-start pulse. All three controls are registered and appear one clock after the inputs that produce them.

Top module: `txt_cursor_overlay`

## Requirements
- R1: While `rst_n` is low, `pix_invert`, `pix_force_on` and `pix_blank` are 0 and the frame count is cleared to 0.
- R2: Cursor mode `crsr_start_cfg[6:5]` = 01 (hidden) never shows the cursor on any cell, line or frame.
- R3: The cursor shows only on the cell whose `cell_addr` equals `crsr_addr` in all 16 bits.
- R4: In mode 00 (steady), the cursor shows on scan lines from `crsr_start_cfg[4:0]` to `crsr_end_line` inclusive.
- R5: When `crsr_start_cfg[4:0]` is greater than `crsr_end_line`, the cursor shows on no scan line.
- R6: The frame count is the number of `frame_start` pulses since reset, modulo 32. In mode 10 the cursor is visible while count bit 3 is 0. In mode 11 it is visible while count bit 4 is 0.
- R7: `pix_invert` is the XOR of attribute bit 6 (cell reverse), `screen_rev` and cursor-visible.
- R8: `pix_force_on` is 1 when attribute bit 4 (underline) is set and `scan_line` equals `ul_line`, and the cell is not blanked.
- R9: `pix_blank` is 1 when attribute bit 5 (blink) is set and the selected phase bit is 1. The phase bit is count bit 3 when `blink_slow_sel` is 0 and count bit 4 when it is 1.
- R10: A blanked cell never has `pix_force_on` set. Blanking does not change `pix_invert`.
- R11: The outputs reflect the inputs sampled at one rising edge, using the frame count from before that edge's increment, and appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-cell clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cell_addr | input | 16 | RAM address of the current character cell |
| scan_line | input | 5 | Scan line within the current character row |
| attr_byte | input | 8 | Cell attribute: bit 6 reverse, bit 5 blink, bit 4 underline; other bits unused here |
| crsr_addr | input | 16 | RAM address of the cursor cell |
| crsr_start_cfg | input | 8 | Bits 6:5 cursor mode, bits 4:0 first cursor scan line |
| crsr_end_line | input | 5 | Last cursor scan line |
| blink_slow_sel | input | 1 | Character blink rate: 0 selects 1/16, 1 selects 1/32 |
| ul_line | input | 5 | Scan line drawn as the underline |
| screen_rev | input | 1 | Reverse the whole screen |
| pix_invert | output | 1 | Invert the shifted row |
| pix_force_on | output | 1 | Force all pixels of the row on |
| pix_blank | output | 1 | Suppress glyph pixels |

## Verification
Some properties are checked on every cycle. The frame count steps by one on each `frame_start` and holds otherwise. A blanked cell never carries an underline. A cell without the blink bit is never blanked. The underline appears only on its programmed line. The hidden mode and an empty line window never add the cursor inversion. The bench scenarios are needed for the rest. These cover the steady-mode line window with its inclusive edges, the address match, and the phase of both cursor blink rates over more than one full wrap of the counter. They also cover the two character blink rates and the three-way XOR of the invert terms. Each of these is compared against a behavioural model on every clock.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    CM_STEADY = 2'b00,
    CM_HIDDEN = 2'b01,
    CM_FAST   = 2'b10,
    CM_SLOW   = 2'b11
  } crsr_mode_e;

  localparam int ATTR_REV_BIT   = 6;
  localparam int ATTR_BLINK_BIT = 5;
  localparam int ATTR_UL_BIT    = 4;

  typedef struct packed {
    logic invert;
    logic force_on;
    logic blank;
  } ovl_ctl_t;
endpackage

// File: rtl/ovl_blink_div.sv
module ovl_blink_div #(
  parameter int CNT_W    = 5,
  parameter int FAST_BIT = 3,
  parameter int SLOW_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic ph_fast,
  output logic ph_slow
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (frame_tick) cnt_q <= cnt_d;
  end

  assign ph_fast = cnt_q[FAST_BIT];
  assign ph_slow = cnt_q[SLOW_BIT];

  // R6: count advances by one per frame pulse
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R6: count holds between frame pulses
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(cnt_q));
endmodule

// File: rtl/ovl_cursor_win.sv
module ovl_cursor_win
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 5
) (
  input  logic [ADDR_W-1:0] cell_addr,
  input  logic [ADDR_W-1:0] crsr_addr,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [LINE_W-1:0] first_line,
  input  logic [LINE_W-1:0] last_line,
  input  crsr_mode_e        mode,
  input  logic              ph_fast,
  input  logic              ph_slow,
  output logic              hit
);
  logic mode_vis, in_band, on_cell;

  always_comb begin
    unique case (mode)
      CM_STEADY: mode_vis = 1'b1;
      CM_HIDDEN: mode_vis = 1'b0;
      CM_FAST:   mode_vis = !ph_fast;
      default:   mode_vis = !ph_slow;
    endcase
  end

  assign on_cell = (cell_addr == crsr_addr);
  assign in_band = (scan_line >= first_line) && (scan_line <= last_line);
  assign hit     = mode_vis && on_cell && in_band;
endmodule

// File: rtl/ovl_attr_mix.sv
module ovl_attr_mix
  import ovl_pkg::*;
#(
  parameter int LINE_W = 5
) (
  input  logic              cell_rev,
  input  logic              cell_blink,
  input  logic              cell_ul,
  input  logic              screen_rev,
  input  logic              crsr_hit,
  input  logic              blink_off_ph,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [LINE_W-1:0] ul_line,
  output ovl_ctl_t          ctl
);
  logic blanked;

  always_comb begin
    blanked      = cell_blink && blink_off_ph;
    ctl.blank    = blanked;
    ctl.force_on = cell_ul && (scan_line == ul_line) && !blanked;
    ctl.invert   = cell_rev ^ screen_rev ^ crsr_hit;
  end
endmodule

// File: rtl/txt_cursor_overlay.sv
module txt_cursor_overlay
  import ovl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LINE_W   = 5,
  parameter int CNT_W    = 5,
  parameter int FAST_BIT = 3,
  parameter int SLOW_BIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [ADDR_W-1:0]   cell_addr,
  input  logic [LINE_W-1:0]   scan_line,
  input  logic [7:0]          attr_byte,
  input  logic [ADDR_W-1:0]   crsr_addr,
  input  logic [LINE_W+2:0]   crsr_start_cfg,
  input  logic [LINE_W-1:0]   crsr_end_line,
  input  logic                blink_slow_sel,
  input  logic [LINE_W-1:0]   ul_line,
  input  logic                screen_rev,
  output logic                pix_invert,
  output logic                pix_force_on,
  output logic                pix_blank
);
  localparam int MODE_LSB = LINE_W;
  localparam int MODE_MSB = LINE_W + 1;

  logic       ph_fast, ph_slow, crsr_hit, blink_off_ph;
  crsr_mode_e mode;
  ovl_ctl_t   ctl_d, ctl_q;
  logic       unused_attr;

  assign unused_attr  = ^{attr_byte[7], attr_byte[3:0], crsr_start_cfg[LINE_W+2]};
  assign mode         = crsr_mode_e'(crsr_start_cfg[MODE_MSB:MODE_LSB]);
  assign blink_off_ph = blink_slow_sel ? ph_slow : ph_fast;

  ovl_blink_div #(.CNT_W(CNT_W), .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_div (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_start),
    .ph_fast(ph_fast), .ph_slow(ph_slow)
  );

  ovl_cursor_win #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_win (
    .cell_addr(cell_addr), .crsr_addr(crsr_addr), .scan_line(scan_line),
    .first_line(crsr_start_cfg[LINE_W-1:0]), .last_line(crsr_end_line),
    .mode(mode), .ph_fast(ph_fast), .ph_slow(ph_slow), .hit(crsr_hit)
  );

  ovl_attr_mix #(.LINE_W(LINE_W)) u_mix (
    .cell_rev(attr_byte[ATTR_REV_BIT]), .cell_blink(attr_byte[ATTR_BLINK_BIT]),
    .cell_ul(attr_byte[ATTR_UL_BIT]), .screen_rev(screen_rev),
    .crsr_hit(crsr_hit), .blink_off_ph(blink_off_ph),
    .scan_line(scan_line), .ul_line(ul_line), .ctl(ctl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign pix_invert   = ctl_q.invert;
  assign pix_force_on = ctl_q.force_on;
  assign pix_blank    = ctl_q.blank;

  // R10: blanking wins over the underline
  assert_blank_no_ul_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_blank |-> !pix_force_on);
  // R9: no blink attribute, no blanking
  assert_noblink_noblank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_byte[ATTR_BLINK_BIT] |=> !pix_blank);
  // R8: underline only on its programmed line
  assert_ul_line_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_line != ul_line) |=> !pix_force_on);
  // R2: hidden mode adds no inversion
  assert_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HIDDEN && !attr_byte[ATTR_REV_BIT] && !screen_rev) |=> !pix_invert);
  // R5: empty line window adds no inversion
  assert_empty_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crsr_start_cfg[LINE_W-1:0] > crsr_end_line && !attr_byte[ATTR_REV_BIT] && !screen_rev)
      |=> !pix_invert);
endmodule

// File: tb/test_txt_cursor_overlay.sv
module test_txt_cursor_overlay;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [15:0] cell_addr, crsr_addr;
  logic [4:0]  scan_line, crsr_end_line, ul_line;
  logic [7:0]  attr_byte, crsr_start_cfg;
  logic        blink_slow_sel, screen_rev;
  logic        pix_invert, pix_force_on, pix_blank;

  int n_cmp = 0;
  int n_bad = 0;
  int frames = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_cursor_overlay i_txt_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cell_addr(cell_addr),
    .scan_line(scan_line), .attr_byte(attr_byte), .crsr_addr(crsr_addr),
    .crsr_start_cfg(crsr_start_cfg), .crsr_end_line(crsr_end_line),
    .blink_slow_sel(blink_slow_sel), .ul_line(ul_line), .screen_rev(screen_rev),
    .pix_invert(pix_invert), .pix_force_on(pix_force_on), .pix_blank(pix_blank)
  );

  function automatic logic [2:0] model();
    int  mode  = int'(crsr_start_cfg[6:5]);
    int  first = int'(crsr_start_cfg[4:0]);
    int  last  = int'(crsr_end_line);
    int  line  = int'(scan_line);
    bit  vis, cur, blank, ul, inv;
    case (mode)
      0: vis = 1;
      1: vis = 0;
      2: vis = ((frames / 8) % 2) == 0;
      default: vis = ((frames / 16) % 2) == 0;
    endcase
    cur   = vis && (cell_addr == crsr_addr) && line >= first && line <= last;
    blank = attr_byte[5] && (((frames / (blink_slow_sel ? 16 : 8)) % 2) == 1);
    ul    = attr_byte[4] && (scan_line == ul_line) && !blank;
    inv   = attr_byte[6] ^ screen_rev ^ cur;
    return {inv, ul, blank};
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {invert,force_on,blank} got %b expected %b", tag, got, exp);
    end
  endtask

  // one clock: predict from current inputs, advance model count, compare after the edge
  task automatic cycle(string tag);
    logic [2:0] exp = model();
    @(posedge clk);
    if (frame_start) frames = (frames + 1) % 32;
    @(negedge clk);
    check(tag, {pix_invert, pix_force_on, pix_blank}, exp);
  endtask

  task automatic defaults();
    frame_start = 0; cell_addr = 16'h0000; crsr_addr = 16'h1234;
    scan_line = 0; attr_byte = 8'h00; crsr_start_cfg = 8'h00;
    crsr_end_line = 5'd7; blink_slow_sel = 0; ul_line = 5'd7; screen_rev = 0;
  endtask

  task automatic frame_pulse(string tag);
    frame_start = 1; cycle(tag); frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 0;
    attr_byte = 8'h70; screen_rev = 1; cell_addr = 16'h1234;
    repeat (3) @(negedge clk);
    check("R1", {pix_invert, pix_force_on, pix_blank}, 3'b000);
    rst_n = 1;
    defaults();
    cycle("R1");

    // R4 steady window lines 2..5 on cursor cell, R11 one-cycle latency
    cell_addr = 16'h1234; crsr_start_cfg = 8'h02; crsr_end_line = 5'd5;
    for (int l = 0; l < 32; l++) begin scan_line = 5'(l); cycle("R4"); end
    // single-line window
    crsr_start_cfg = 8'h06; crsr_end_line = 5'd6;
    for (int l = 4; l < 9; l++) begin scan_line = 5'(l); cycle("R4"); end
    // R3 neighbour addresses never show the cursor
    crsr_start_cfg = 8'h00; crsr_end_line = 5'd31; scan_line = 5'd3;
    foreach (cell_addr[b]) begin cell_addr = 16'h1234 ^ (16'h1 << b); cycle("R3"); end
    cell_addr = 16'h1234; cycle("R3");
    // R5 start after end
    crsr_start_cfg = 8'h09; crsr_end_line = 5'd4;
    for (int l = 0; l < 16; l++) begin scan_line = 5'(l); cycle("R5"); end
    // R2 hidden across frames
    crsr_start_cfg = 8'h20; crsr_end_line = 5'd31; scan_line = 5'd1;
    for (int f = 0; f < 40; f++) begin frame_pulse("R2"); cycle("R2"); end
    // R6 fast and slow cursor blink over more than a full wrap
    crsr_start_cfg = 8'h40;
    for (int f = 0; f < 70; f++) begin frame_pulse("R6"); cycle("R6"); end
    crsr_start_cfg = 8'h60;
    for (int f = 0; f < 70; f++) begin frame_pulse("R6"); cycle("R6"); end
    // R7 XOR of reverse terms with cursor
    crsr_start_cfg = 8'h00;
    for (int k = 0; k < 8; k++) begin
      attr_byte = k[0] ? 8'h40 : 8'h00; screen_rev = k[1];
      cell_addr = k[2] ? 16'h1234 : 16'h0001; cycle("R7");
    end
    // R8 underline on its line only
    screen_rev = 0; attr_byte = 8'h10; ul_line = 5'd9; cell_addr = 16'h0002;
    for (int l = 0; l < 12; l++) begin scan_line = 5'(l); cycle("R8"); end
    // R9 and R10 character blink, both rates, with underline and reverse
    attr_byte = 8'h70; scan_line = 5'd9;
    for (int s = 0; s < 2; s++) begin
      blink_slow_sel = s[0];
      for (int f = 0; f < 40; f++) begin frame_pulse("R9"); cycle("R10"); end
    end
    // mixed random stimulus, all rules together
    for (int i = 0; i < 600; i++) begin
      cell_addr = ($urandom % 4 == 0) ? crsr_addr : 16'($urandom);
      scan_line = 5'($urandom); attr_byte = 8'($urandom);
      crsr_start_cfg = 8'($urandom); crsr_end_line = 5'($urandom);
      blink_slow_sel = 1'($urandom); ul_line = 5'($urandom);
      screen_rev = 1'($urandom); frame_start = ($urandom % 5 == 0);
      cycle("R11");
    end
    frame_start = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule